// File: doc/BRIEF.md
# I2C Quick-Command Bus Master

This block runs a zero-length I2C/SMBus transaction, the quick command, by pulling the clock and data lines low itself and timing each bus phase in system clocks. A host gives a 7-bit target address, a direction bit, a speed select (standard or fast) and a one-cycle start request. The block then waits for an idle bus and issues a START condition, the address frame and one acknowledge clock, followed by a STOP condition. It finishes with a one-cycle completion pulse and a 2-bit outcome: acknowledged, not acknowledged, bus stuck, or request refused.

Both lines are open drain. The block only asserts pull-low enables, and it reads the real line levels back through a synchronizer. Whenever the block releases a line and needs it to go high, it waits for the line to read high. This lets a target stretch the clock. A timeout turns a line held low for too long into a bus-stuck outcome, which is reported apart from a NACK. The phase lengths come from fixed nanosecond figures for each speed. They are converted to clock counts from a clock-frequency parameter, and each count is rounded up.

Top module: `i2c_quick_master`

## Requirements
- R1: After reset, and whenever `busy` is low, both pull-low enables are off; `busy` and `done` are low after reset.
- R2: A start request with `tenBitReq` high is refused: in the next cycle `done` pulses with result 3 (invalid), `busy` stays low and neither line is ever pulled.
- R3: Before START the block releases both lines and waits until both read high, then holds them released for the bus-free time. If either line is still low after `TIMEOUT_CYC` cycles, it ends with result 2 (stuck) and no START is issued. Neither line is pulled in the first busy cycle.
- R4: START is SDA going low while SCL is high. SCL is pulled low only after the START hold time, and exactly one START appears per transaction.
- R5: The frame is `{addrReq, readReq}` (address in bits 7..1, direction in bit 0), sent MSB first over 8 clocks. SDA changes only while SCL is low, at the midpoint of the low time.
- R6: Each of the 9 address and acknowledge clocks keeps SCL low for 2 x ceil(low/2) cycles. After SCL reads high, SCL is held high for the high time. Standard mode uses low 4700 ns and high 4000 ns. Fast mode uses low 1300 ns and high 600 ns.
- R7: In the ninth clock SDA is released and sampled once SCL reads high. Low gives result 0 (ACK) and high gives result 1 (NACK).
- R8: A target that holds SCL low for fewer than `TIMEOUT_CYC` cycles only delays the transaction. The frame and the result are unchanged.
- R9: If SCL does not read high within `TIMEOUT_CYC` cycles of being released, the transaction ends with result 2 (stuck) and both lines released.
- R10: STOP pulls both lines low for the full low time, releases SCL, waits for SCL to read high, waits the STOP setup time and then releases SDA while SCL is high. `done` follows after the bus-free time.
- R11: `busy` rises in the cycle after an accepted start request and falls in the cycle in which `done` pulses for one cycle with the result. Start requests while `busy` is high are ignored.
- R12: Nanosecond timings are converted to cycles as ceil(ns x `CLK_KHZ` / 1e6). Standard mode uses START hold 4000, STOP setup 4000 and bus free 4700 ns. Fast mode uses 600, 600 and 1300 ns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| startReq | input | 1 | One-cycle transaction request, taken while idle |
| addrReq | input | 7 | Target address |
| readReq | input | 1 | Direction bit placed in frame bit 0 |
| tenBitReq | input | 1 | Request asks for a 10-bit address (refused) |
| fastMode | input | 1 | 1 selects fast-mode timing, 0 standard |
| sclIn | input | 1 | SCL line level |
| sdaIn | input | 1 | SDA line level |
| sclDrvLow | output | 1 | Pull SCL low when 1 |
| sdaDrvLow | output | 1 | Pull SDA low when 1 |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | 2 | 0 ACK, 1 NACK, 2 stuck, 3 invalid; valid with done |

## Verification
The properties assume that the request inputs are synchronous to `clk` and that `tenBitReq` is only meaningful in the cycle of `startReq`. They also assume that the line inputs are the wired-AND of this block's enables and the other devices on the bus, so the block itself never sees a line high that it is pulling low. The bench keeps to this. It changes request inputs well away from clock edges, pulses `startReq` for a single cycle, and builds both line levels from the block's enables together with a target model. That model only pulls SDA for the acknowledge, holds SCL for a bounded or unbounded stretch, or keeps SDA low before a transaction to emulate a hung bus.

// File: rtl/i2c_quick_pkg.sv
package i2c_quick_pkg;

  localparam int ADDR_BITS  = 7;
  localparam int FRAME_BITS = ADDR_BITS + 1;

  // Phase lengths in nanoseconds, per speed
  localparam int STD_HOLD_NS  = 4000;
  localparam int STD_SETUP_NS = 4000;
  localparam int STD_LOW_NS   = 4700;
  localparam int STD_HIGH_NS  = 4000;
  localparam int STD_FREE_NS  = 4700;
  localparam int FST_HOLD_NS  = 600;
  localparam int FST_SETUP_NS = 600;
  localparam int FST_LOW_NS   = 1300;
  localparam int FST_HIGH_NS  = 600;
  localparam int FST_FREE_NS  = 1300;

  typedef enum logic [1:0] {
    RES_ACK     = 2'd0,
    RES_NACK    = 2'd1,
    RES_STUCK   = 2'd2,
    RES_INVALID = 2'd3
  } qcResult_e;

  typedef enum logic [2:0] {
    TM_FREE,
    TM_HOLD,
    TM_HALF,
    TM_LOW,
    TM_HIGH,
    TM_SETUP
  } qcTime_e;

  // Strobes from the sequencer to the datapath
  typedef struct packed {
    logic    capture;
    logic    load;
    qcTime_e timeSel;
    logic    sclPull;
    logic    sclRelease;
    logic    sdaPull;
    logic    sdaRelease;
    logic    sdaBit;
    logic    shift;
    logic    sampleAck;
    logic    toRun;
  } qcStrobe_t;

  // ceil(ns * kHz / 1e6)
  function automatic int nsToCycles(input int ns, input int clkKhz);
    longint prod;
    prod = longint'(ns) * longint'(clkKhz);
    return int'((prod + longint'(999999)) / longint'(1000000));
  endfunction

endpackage

// File: rtl/i2c_quick_dp.sv
module i2c_quick_dp
  import i2c_quick_pkg::*;
#(
  parameter int CLK_KHZ     = 125000,
  parameter int TIMEOUT_CYC = 4096,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  qcStrobe_t            stb,
  input  logic [ADDR_BITS-1:0] addrReq,
  input  logic                 readReq,
  input  logic                 fastMode,
  input  logic                 sclIn,
  input  logic                 sdaIn,
  output logic                 sclDrvLow,
  output logic                 sdaDrvLow,
  output logic                 cntZero,
  output logic                 sclHigh,
  output logic                 sdaHigh,
  output logic                 toExpired,
  output logic                 bitLast,
  output logic                 nackSeen
);

  localparam int S_HOLD_C  = nsToCycles(STD_HOLD_NS,    CLK_KHZ);
  localparam int S_SETUP_C = nsToCycles(STD_SETUP_NS,   CLK_KHZ);
  localparam int S_LOW_C   = nsToCycles(STD_LOW_NS,     CLK_KHZ);
  localparam int S_HALF_C  = nsToCycles(STD_LOW_NS / 2, CLK_KHZ);
  localparam int S_HIGH_C  = nsToCycles(STD_HIGH_NS,    CLK_KHZ);
  localparam int S_FREE_C  = nsToCycles(STD_FREE_NS,    CLK_KHZ);
  localparam int F_HOLD_C  = nsToCycles(FST_HOLD_NS,    CLK_KHZ);
  localparam int F_SETUP_C = nsToCycles(FST_SETUP_NS,   CLK_KHZ);
  localparam int F_LOW_C   = nsToCycles(FST_LOW_NS,     CLK_KHZ);
  localparam int F_HALF_C  = nsToCycles(FST_LOW_NS / 2, CLK_KHZ);
  localparam int F_HIGH_C  = nsToCycles(FST_HIGH_NS,    CLK_KHZ);
  localparam int F_FREE_C  = nsToCycles(FST_FREE_NS,    CLK_KHZ);

  localparam int MAX_C = (S_FREE_C > S_LOW_C) ? S_FREE_C : S_LOW_C;
  localparam int CNT_W = $clog2(MAX_C + 1);
  localparam int TO_W  = $clog2(TIMEOUT_CYC + 1);
  localparam int BIT_W = $clog2(FRAME_BITS + 1);

  // Line synchronizers
  logic [SYNC_STAGES-1:0] sclSync;
  logic [SYNC_STAGES-1:0] sdaSync;

  genvar g;
  generate
    for (g = 0; g < SYNC_STAGES; g++) begin : g_sync
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (!rstN) begin
            sclSync[0] <= 1'b1;
            sdaSync[0] <= 1'b1;
          end else begin
            sclSync[0] <= sclIn;
            sdaSync[0] <= sdaIn;
          end
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (!rstN) begin
            sclSync[g] <= 1'b1;
            sdaSync[g] <= 1'b1;
          end else begin
            sclSync[g] <= sclSync[g-1];
            sdaSync[g] <= sdaSync[g-1];
          end
        end
      end
    end
  endgenerate

  assign sclHigh = sclSync[SYNC_STAGES-1];
  assign sdaHigh = sdaSync[SYNC_STAGES-1];

  // Phase counter
  logic             fastSel;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] loadVal;

  always_comb begin
    unique case (stb.timeSel)
      TM_FREE:  loadVal = fastSel ? CNT_W'(F_FREE_C - 1)  : CNT_W'(S_FREE_C - 1);
      TM_HOLD:  loadVal = fastSel ? CNT_W'(F_HOLD_C - 1)  : CNT_W'(S_HOLD_C - 1);
      TM_HALF:  loadVal = fastSel ? CNT_W'(F_HALF_C - 1)  : CNT_W'(S_HALF_C - 1);
      TM_LOW:   loadVal = fastSel ? CNT_W'(F_LOW_C - 1)   : CNT_W'(S_LOW_C - 1);
      TM_HIGH:  loadVal = fastSel ? CNT_W'(F_HIGH_C - 1)  : CNT_W'(S_HIGH_C - 1);
      TM_SETUP: loadVal = fastSel ? CNT_W'(F_SETUP_C - 1) : CNT_W'(S_SETUP_C - 1);
      default:  loadVal = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt <= '0;
    end else if (stb.load) begin
      cnt <= loadVal;
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign cntZero = (cnt == '0);

  // Frame shifter
  logic [FRAME_BITS-1:0] shReg;
  logic [BIT_W-1:0]      bitCnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shReg    <= '0;
      bitCnt   <= '0;
      fastSel  <= 1'b0;
      nackSeen <= 1'b0;
    end else begin
      if (stb.capture) begin
        shReg    <= {addrReq, readReq};
        bitCnt   <= '0;
        fastSel  <= fastMode;
        nackSeen <= 1'b0;
      end else if (stb.shift) begin
        shReg  <= {shReg[FRAME_BITS-2:0], 1'b0};
        bitCnt <= bitCnt + 1'b1;
      end
      if (stb.sampleAck && bitLast) begin
        nackSeen <= sdaHigh;
      end
    end
  end

  assign bitLast = (bitCnt == BIT_W'(FRAME_BITS));

  // Line enables
  always_ff @(posedge clk) begin
    if (!rstN) begin
      sclDrvLow <= 1'b0;
      sdaDrvLow <= 1'b0;
    end else begin
      if (stb.sclPull) begin
        sclDrvLow <= 1'b1;
      end else if (stb.sclRelease) begin
        sclDrvLow <= 1'b0;
      end
      if (stb.sdaPull) begin
        sdaDrvLow <= 1'b1;
      end else if (stb.sdaRelease) begin
        sdaDrvLow <= 1'b0;
      end else if (stb.sdaBit) begin
        sdaDrvLow <= bitLast ? 1'b0 : ~shReg[FRAME_BITS-1];
      end
    end
  end

  // Line-high timeout
  logic [TO_W-1:0] toCnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      toCnt <= '0;
    end else if (!stb.toRun) begin
      toCnt <= '0;
    end else if (!toExpired) begin
      toCnt <= toCnt + 1'b1;
    end
  end

  assign toExpired = (toCnt == TO_W'(TIMEOUT_CYC - 1));

endmodule

// File: rtl/i2c_quick_ctrl.sv
module i2c_quick_ctrl
  import i2c_quick_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       startReq,
  input  logic       tenBitReq,
  input  logic       cntZero,
  input  logic       sclHigh,
  input  logic       sdaHigh,
  input  logic       toExpired,
  input  logic       bitLast,
  input  logic       nackSeen,
  output qcStrobe_t  stb,
  output logic       busy,
  output logic       done,
  output logic [1:0] result
);

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_FREE,
    ST_BUF,
    ST_HOLD,
    ST_LOWA,
    ST_LOWB,
    ST_RISE,
    ST_HIGH,
    ST_STOPLOW,
    ST_STOPRISE,
    ST_SETUP,
    ST_TAIL
  } qcState_e;

  qcState_e  state, nxt;
  logic      finish;
  qcResult_e code;

  always_comb begin
    stb    = '0;
    nxt    = state;
    finish = 1'b0;
    code   = RES_ACK;
    unique case (state)
      ST_IDLE: begin
        if (startReq) begin
          if (tenBitReq) begin
            finish = 1'b1;
            code   = RES_INVALID;
          end else begin
            stb.capture    = 1'b1;
            stb.sclRelease = 1'b1;
            stb.sdaRelease = 1'b1;
            nxt            = ST_FREE;
          end
        end
      end
      ST_FREE: begin
        stb.toRun = 1'b1;
        if (sclHigh && sdaHigh) begin
          stb.load    = 1'b1;
          stb.timeSel = TM_FREE;
          nxt         = ST_BUF;
        end else if (toExpired) begin
          finish = 1'b1;
          code   = RES_STUCK;
          nxt    = ST_IDLE;
        end
      end
      ST_BUF: begin
        if (cntZero) begin
          stb.sdaPull = 1'b1;
          stb.load    = 1'b1;
          stb.timeSel = TM_HOLD;
          nxt         = ST_HOLD;
        end
      end
      ST_HOLD: begin
        if (cntZero) begin
          stb.sclPull = 1'b1;
          stb.load    = 1'b1;
          stb.timeSel = TM_HALF;
          nxt         = ST_LOWA;
        end
      end
      ST_LOWA: begin
        if (cntZero) begin
          stb.sdaBit  = 1'b1;
          stb.load    = 1'b1;
          stb.timeSel = TM_HALF;
          nxt         = ST_LOWB;
        end
      end
      ST_LOWB: begin
        if (cntZero) begin
          stb.sclRelease = 1'b1;
          nxt            = ST_RISE;
        end
      end
      ST_RISE: begin
        stb.toRun = 1'b1;
        if (sclHigh) begin
          stb.sampleAck = 1'b1;
          stb.load      = 1'b1;
          stb.timeSel   = TM_HIGH;
          nxt           = ST_HIGH;
        end else if (toExpired) begin
          finish = 1'b1;
          code   = RES_STUCK;
          nxt    = ST_IDLE;
        end
      end
      ST_HIGH: begin
        if (cntZero) begin
          stb.sclPull = 1'b1;
          stb.load    = 1'b1;
          if (bitLast) begin
            stb.sdaPull = 1'b1;
            stb.timeSel = TM_LOW;
            nxt         = ST_STOPLOW;
          end else begin
            stb.shift   = 1'b1;
            stb.timeSel = TM_HALF;
            nxt         = ST_LOWA;
          end
        end
      end
      ST_STOPLOW: begin
        if (cntZero) begin
          stb.sclRelease = 1'b1;
          nxt            = ST_STOPRISE;
        end
      end
      ST_STOPRISE: begin
        stb.toRun = 1'b1;
        if (sclHigh) begin
          stb.load    = 1'b1;
          stb.timeSel = TM_SETUP;
          nxt         = ST_SETUP;
        end else if (toExpired) begin
          finish = 1'b1;
          code   = RES_STUCK;
          nxt    = ST_IDLE;
        end
      end
      ST_SETUP: begin
        if (cntZero) begin
          stb.sdaRelease = 1'b1;
          stb.load       = 1'b1;
          stb.timeSel    = TM_FREE;
          nxt            = ST_TAIL;
        end
      end
      ST_TAIL: begin
        if (cntZero) begin
          finish = 1'b1;
          code   = nackSeen ? RES_NACK : RES_ACK;
          nxt    = ST_IDLE;
        end
      end
      default: nxt = ST_IDLE;
    endcase
    // Any early end lets go of both lines
    if (finish && code == RES_STUCK) begin
      stb.sclRelease = 1'b1;
      stb.sdaRelease = 1'b1;
      stb.sclPull    = 1'b0;
      stb.sdaPull    = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      done   <= 1'b0;
      result <= RES_ACK;
    end else begin
      state <= nxt;
      done  <= finish;
      if (finish) begin
        result <= code;
      end
    end
  end

  assign busy = (state != ST_IDLE);

endmodule

// File: rtl/i2c_quick_master.sv
module i2c_quick_master
  import i2c_quick_pkg::*;
#(
  parameter int CLK_KHZ     = 125000,
  parameter int TIMEOUT_CYC = 4096,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 startReq,
  input  logic [ADDR_BITS-1:0] addrReq,
  input  logic                 readReq,
  input  logic                 tenBitReq,
  input  logic                 fastMode,
  input  logic                 sclIn,
  input  logic                 sdaIn,
  output logic                 sclDrvLow,
  output logic                 sdaDrvLow,
  output logic                 busy,
  output logic                 done,
  output logic [1:0]           result
);

  qcStrobe_t stb;
  logic cntZero, sclHigh, sdaHigh, toExpired, bitLast, nackSeen;

  i2c_quick_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .startReq  (startReq),
    .tenBitReq (tenBitReq),
    .cntZero   (cntZero),
    .sclHigh   (sclHigh),
    .sdaHigh   (sdaHigh),
    .toExpired (toExpired),
    .bitLast   (bitLast),
    .nackSeen  (nackSeen),
    .stb       (stb),
    .busy      (busy),
    .done      (done),
    .result    (result)
  );

  i2c_quick_dp #(
    .CLK_KHZ     (CLK_KHZ),
    .TIMEOUT_CYC (TIMEOUT_CYC),
    .SYNC_STAGES (SYNC_STAGES)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .addrReq   (addrReq),
    .readReq   (readReq),
    .fastMode  (fastMode),
    .sclIn     (sclIn),
    .sdaIn     (sdaIn),
    .sclDrvLow (sclDrvLow),
    .sdaDrvLow (sdaDrvLow),
    .cntZero   (cntZero),
    .sclHigh   (sclHigh),
    .sdaHigh   (sdaHigh),
    .toExpired (toExpired),
    .bitLast   (bitLast),
    .nackSeen  (nackSeen)
  );

endmodule

// File: rtl/i2c_quick_checker.sv
module i2c_quick_checker (
  input logic       clk,
  input logic       rstN,
  input logic       startReq,
  input logic       tenBitReq,
  input logic       busy,
  input logic       done,
  input logic [1:0] result,
  input logic       sclDrvLow,
  input logic       sdaDrvLow
);

  p_idle_released_r1: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (!sclDrvLow && !sdaDrvLow));

  p_refuse_ten_bit_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && startReq && tenBitReq) |=> (done && result == 2'd3 && !busy));

  p_quiet_first_cycle_r3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> (!sclDrvLow && !sdaDrvLow));

  p_launch_r11: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && startReq && !tenBitReq) |=> busy);

  p_done_when_idle_r11: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);

  p_end_with_done_r11: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> done);

endmodule

bind i2c_quick_master i2c_quick_checker u_checker (
  .clk       (clk),
  .rstN      (rstN),
  .startReq  (startReq),
  .tenBitReq (tenBitReq),
  .busy      (busy),
  .done      (done),
  .result    (result),
  .sclDrvLow (sclDrvLow),
  .sdaDrvLow (sdaDrvLow)
);

// File: tb/i2c_quick_master_bench.sv
`timescale 1ns/1ps
module i2c_quick_master_bench;

  localparam int TO_CYC   = 1500;
  localparam int WD_LIMIT = 190000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic startReq = 1'b0;
  logic [6:0] addrReq = '0;
  logic readReq = 1'b0;
  logic tenBitReq = 1'b0;
  logic fastMode = 1'b1;
  logic sclDrvLow, sdaDrvLow, busy, done;
  logic [1:0] result;

  // target model and monitor state (written only by the monitor)
  bit slaveSda = 0, stretchHold = 0, stretchDone = 0;
  int holdLeft = 0;
  int rises = 0, run = 1, startCnt = 0, stopCnt = 0;
  bit anyPull = 0, prevScl = 1, prevSda = 1;
  logic [7:0] capByte = '0;
  int lowLen [16];
  int highLen [16];

  // bench configuration (written only by the stimulus)
  bit monClr = 0, ackEnable = 0, holdSdaBus = 0;
  int stretchBit = -1, stretchCyc = 0;

  int checks = 0, errors = 0, cycles = 0;
  bit finished = 0;

  wire sclLine = !sclDrvLow && !stretchHold;
  wire sdaLine = !sdaDrvLow && !slaveSda && !holdSdaBus;

  i2c_quick_master #(.CLK_KHZ(125000), .TIMEOUT_CYC(TO_CYC)) u_i2c_quick_master (
    .clk(clk), .rstN(rstN), .startReq(startReq), .addrReq(addrReq),
    .readReq(readReq), .tenBitReq(tenBitReq), .fastMode(fastMode),
    .sclIn(sclLine), .sdaIn(sdaLine), .sclDrvLow(sclDrvLow),
    .sdaDrvLow(sdaDrvLow), .busy(busy), .done(done), .result(result)
  );

  always #4 clk = ~clk;

  function automatic int nsCyc(input int ns);
    return int'((longint'(ns) * 125000 + 999999) / 1000000);
  endfunction

  function automatic int expCode(input bit ack);
    return ack ? 0 : 1;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles >= WD_LIMIT && !finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual %0d expected %0d", cycles, WD_LIMIT);
      finishRun();
    end
  end

  // Bus monitor and target model
  always @(negedge clk) begin
    bit sNow, dNow;
    sNow = sclLine;
    dNow = sdaLine;
    if (monClr) begin
      rises = 0; run = 1; startCnt = 0; stopCnt = 0; anyPull = 0;
      capByte = '0; slaveSda = 0; stretchHold = 0; stretchDone = 0; holdLeft = 0;
    end else begin
      if (sclDrvLow || sdaDrvLow) anyPull = 1;
      if (sNow && prevScl && prevSda && !dNow) startCnt++;
      if (sNow && prevScl && !prevSda && dNow) stopCnt++;
      if (sNow == prevScl) begin
        run++;
      end else begin
        if (sNow) begin
          if (rises < 16) lowLen[rises] = run;
          if (rises < 8) capByte = {capByte[6:0], dNow};
          rises++;
        end else if (rises > 0 && rises <= 16) begin
          highLen[rises-1] = run;
        end
        run = 1;
      end
      if (!sNow && ackEnable && rises == 8) slaveSda = 1;
      else if (!sNow && rises >= 9) slaveSda = 0;
      if (stretchBit < 0) begin
        stretchHold = 0;
        stretchDone = 0;
      end else if (!stretchDone && !stretchHold && !sNow && rises == stretchBit) begin
        stretchHold = 1;
        holdLeft = stretchCyc;
      end else if (stretchHold && !sclDrvLow) begin
        if (holdLeft <= 1) begin
          stretchHold = 0;
          stretchDone = 1;
        end else begin
          holdLeft--;
        end
      end
    end
    prevScl = sNow;
    prevSda = dNow;
  end

  task automatic clearMon();
    @(posedge clk); #1;
    monClr = 1;
    @(posedge clk); #1;
    monClr = 0;
  endtask

  // Launch a request; returns result and cycles waited
  task automatic launch(input logic [6:0] a, input bit rw, input bit fast, input bit ten,
                        input bit poke, output int res, output int waited);
    addrReq = a; readReq = rw; fastMode = fast; tenBitReq = ten; startReq = 1;
    @(posedge clk); #1;
    startReq = 0; tenBitReq = 0;
    @(negedge clk);
    if (!ten) check(busy === 1'b1, "R11", "busy after start", busy, 1);
    waited = 0;
    while (done !== 1'b1 && waited < 60000) begin
      if (poke && waited == 100) begin
        startReq = 1; tenBitReq = 1; addrReq = ~a;
      end else if (poke && waited == 101) begin
        startReq = 0; tenBitReq = 0; addrReq = a;
      end
      @(negedge clk);
      waited++;
    end
    res = result;
    check(done === 1'b1, "R11", "done seen", done, 1);
    check(busy === 1'b0, "R11", "busy low with done", busy, 0);
    check(!sclDrvLow && !sdaDrvLow, "R1", "lines released at done",
          {sclDrvLow, sdaDrvLow}, 0);
    @(negedge clk);
    check(done === 1'b0, "R11", "done is one cycle", done, 0);
  endtask

  task automatic fullTxn(input logic [6:0] a, input bit rw, input bit fast, input bit ack,
                         input int sBit, input int sCyc, input bit poke);
    int res, waited, half, lowC, highC;
    half  = nsCyc((fast ? 1300 : 4700) / 2);
    lowC  = nsCyc(fast ? 1300 : 4700);
    highC = nsCyc(fast ? 600 : 4000);
    ackEnable = ack; stretchBit = sBit; stretchCyc = sCyc;
    clearMon();
    launch(a, rw, fast, 1'b0, poke, res, waited);
    check(res == expCode(ack), "R7", "ack result", res, expCode(ack));
    check(capByte == {a, rw}, "R5", "frame byte", capByte, {a, rw});
    check(startCnt == 1, "R4", "start count", startCnt, 1);
    check(stopCnt == 1, "R10", "stop count", stopCnt, 1);
    check(rises == 10, "R10", "scl rises", rises, 10);
    for (int i = 0; i < 9; i++) begin
      if (i == sBit) begin
        check(lowLen[i] >= 2 * half + sCyc - 10, "R8", "stretched low", lowLen[i], 2 * half + sCyc);
      end else begin
        check(lowLen[i] == 2 * half, "R6", "scl low cycles", lowLen[i], 2 * half);
      end
      check(highLen[i] >= highC + 1 && highLen[i] <= highC + 4, "R6", "scl high cycles",
            highLen[i], highC + 3);
    end
    check(lowLen[9] == lowC, "R10", "stop low cycles", lowLen[9], lowC);
    stretchBit = -1;
  endtask

  initial begin
    int res, waited, seedInit;
    seedInit = $urandom(32'd4242);
    repeat (5) @(posedge clk);
    @(negedge clk);
    check(busy === 1'b0 && done === 1'b0, "R1", "reset busy/done", {busy, done}, 0);
    check(!sclDrvLow && !sdaDrvLow, "R1", "reset lines", {sclDrvLow, sdaDrvLow}, 0);
    @(posedge clk); #1;
    rstN = 1;
    repeat (4) @(posedge clk);
    #1;

    // R12: conversion figures used by the timing checks
    check(nsCyc(4700 / 2) == 294 && nsCyc(1300 / 2) == 82, "R12", "half-low rounding",
          nsCyc(1300 / 2), 82);

    // R2 refused request
    clearMon();
    launch(7'h2A, 1'b0, 1'b1, 1'b1, 1'b0, res, waited);
    check(res == 3, "R2", "invalid result", res, 3);
    repeat (20) @(negedge clk);
    check(anyPull == 0 && startCnt == 0, "R2", "no bus activity", anyPull, 0);

    // Directed standard-mode transactions
    fullTxn(7'h50, 1'b0, 1'b0, 1'b1, -1, 0, 1'b0);
    fullTxn(7'h0F, 1'b1, 1'b0, 1'b0, -1, 0, 1'b0);

    // R11 start while busy is ignored
    fullTxn(7'h33, 1'b1, 1'b1, 1'b1, -1, 0, 1'b1);

    // R8 clock stretch within timeout
    fullTxn(7'h45, 1'b0, 1'b1, 1'b1, 5, 200, 1'b0);
    fullTxn(7'h7F, 1'b1, 1'b1, 1'b0, 8, 300, 1'b0);

    // R3 bus never free
    holdSdaBus = 1;
    clearMon();
    launch(7'h11, 1'b0, 1'b1, 1'b0, 1'b0, res, waited);
    check(res == 2, "R3", "stuck result on busy bus", res, 2);
    check(waited >= TO_CYC, "R3", "waited for timeout", waited, TO_CYC);
    check(startCnt == 0, "R3", "no start on stuck bus", startCnt, 0);
    @(posedge clk); #1;
    holdSdaBus = 0;

    // R9 SCL held low forever
    stretchBit = 3; stretchCyc = 1000000; ackEnable = 1;
    clearMon();
    launch(7'h24, 1'b0, 1'b1, 1'b0, 1'b0, res, waited);
    check(res == 2, "R9", "stuck on held scl", res, 2);
    check(rises == 3, "R9", "rises before stuck", rises, 3);
    @(posedge clk); #1;
    stretchBit = -1;
    repeat (10) @(posedge clk);

    // Constrained random fast-mode transactions
    for (int n = 0; n < 10; n++) begin
      logic [6:0] a;
      bit rw, ack;
      a   = 7'($urandom % 128);
      rw  = 1'($urandom % 2);
      ack = 1'($urandom % 2);
      fullTxn(a, rw, 1'b1, ack, -1, 0, 1'b0);
    end

    finishRun();
  end

endmodule